// File: doc/BRIEF.md
# Capacitive Touch Pad Sampler

The block reads a set of capacitive touch pads. Each pad is a bidirectional pin. Outside the chip it has a pull-up resistor to the supply and a capacitor to ground. A finger on the pad adds capacitance, so the pad charges more slowly after it is let go from a forced low level. The block runs a fixed repeating scan. It first drains every pad to ground for long enough to empty the capacitor. It then stops driving all pads. One clock later it takes a single snapshot of every pad at once. A pad that still reads low at that snapshot counts as touched. A pad that has already risen counts as free.

The pin is split into an enable, a drive value and a sampled input. This lets the surrounding pad ring, or a test model of the resistor and capacitor, supply the charge delay in whole clock cycles. The snapshot passes through a synchronizer before it is decoded.

The decoder produces three outputs:
- a level vector of touched pads;
- a single-cycle pulse for every pad that has become touched since the previous snapshot;
- a toggle bit per pad that flips on each such pulse.

If every pad reads low, no touch is reported. That reading cannot be told apart from the case where nothing on the pads rises at all.

Top module: `touch_pad_sampler`

## Requirements
- R1: During reset, and for the first DRAIN_CYCLES cycles of every scan period, all bits of `pad_oe` are 1.
- R2: After the drain, `pad_oe` is 0 on all pads for the rest of the period. The period is PERIOD_CYCLES cycles long, and the drain starts again at cycle 0 of the next period.
- R3: The pad input level in cycle DRAIN_CYCLES+1 of a period, one cycle after release, decides each pad's state: low means touched (`pressed` bit 1), high means free. A pad still low at that cycle counts as touched however late it rises. A pad already high counts as free however early it rose. The new `pressed` value appears in cycle DRAIN_CYCLES+SYNC_STAGES+2 of the period and holds until the next snapshot's update.
- R4: Any combination of one, two or three touched pads is reported exactly, bit i of `pressed` belonging to pad i.
- R5: A snapshot in which all pads read low is reported as no touch: `pressed` is all zeros and no pulse is raised.
- R6: `press_pulse` bit i is 1 for exactly one cycle, the cycle in which `pressed` updates, when pad i is touched in the new snapshot and was not touched in the previous one. It is 0 in every other case.
- R7: `toggle` bit i inverts in the cycle its `press_pulse` bit is 1 and changes at no other time. A pad going from touched to free does not change it.
- R8: Synchronous active-high reset clears `pressed`, `press_pulse`, `toggle` and the stored previous snapshot. The next snapshot after reset is therefore compared against all pads free.
- R9: `pad_out` is 0 on all pads at all times, so an enabled pad always pulls toward ground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_in | input | NUM_PADS | Level read back from each pad |
| pad_oe | output | NUM_PADS | Drive enable for each pad, 1 = driven |
| pad_out | output | NUM_PADS | Drive value for each pad, always 0 |
| pressed | output | NUM_PADS | Touched state from the latest snapshot |
| press_pulse | output | NUM_PADS | One-cycle flag for each newly touched pad |
| toggle | output | NUM_PADS | Per-pad state that flips on each new touch |

## Verification
A new touch on one pad and a release on another pad can come from the same snapshot. That single update must then raise a pulse and flip the toggle bit only for the new touch, while the released pad just clears its `pressed` bit. The bench provokes every such mix by sweeping each of the sixteen pad patterns against each of the sixteen, the all-low pattern included. It computes the expected pulse and toggle with bitwise arithmetic on the masked patterns and judges all three outputs in the one cycle in which they update. It then checks in the following cycle that the pulse has cleared.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic {
        PH_DRAIN = 1'b0,
        PH_FLOAT = 1'b1
    } tps_phase_e;

    typedef struct packed {
        logic drive;
        logic strobe;
    } tps_seq_t;

endpackage

// File: rtl/tps_sequencer.sv
module tps_sequencer
    import tps_pkg::*;
#(
    parameter int NUM_PADS      = 4,
    parameter int DRAIN_CYCLES  = 8,
    parameter int PERIOD_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                strobe
);
    localparam int CW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST  = CW'(PERIOD_CYCLES - 1);
    localparam logic [CW-1:0] DRAIN = CW'(DRAIN_CYCLES);
    localparam logic [CW-1:0] SAMP  = CW'(DRAIN_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    tps_phase_e    phase;
    tps_seq_t      seq;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        phase      = (cnt_q < DRAIN) ? PH_DRAIN : PH_FLOAT;
        seq.drive  = (phase == PH_DRAIN);
        seq.strobe = (cnt_q == SAMP);
    end

    assign pad_oe = {NUM_PADS{seq.drive}};
    assign strobe = seq.strobe;

    // R1
    wrap_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (&pad_oe));

    // R2
    float_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pad_oe[0] && cnt_q != LAST) |=> !pad_oe[0]);

    // R3
    strobe_float_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (pad_oe == '0 && $past(pad_oe) == '0));

endmodule

// File: rtl/tps_sync.sv
module tps_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    input  logic             tag_in,
    output logic [WIDTH-1:0] q,
    output logic             tag_out
);
    logic [WIDTH-1:0] data_q [STAGES];
    logic [STAGES-1:0] tag_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        data_q[0] <= '1;
                        tag_q[0]  <= 1'b0;
                    end else begin
                        data_q[0] <= d;
                        tag_q[0]  <= tag_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        data_q[s] <= '1;
                        tag_q[s]  <= 1'b0;
                    end else begin
                        data_q[s] <= data_q[s-1];
                        tag_q[s]  <= tag_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign q       = data_q[STAGES-1];
    assign tag_out = tag_q[STAGES-1];

endmodule

// File: rtl/tps_decoder.sv
module tps_decoder #(
    parameter int NUM_PADS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic [NUM_PADS-1:0] level,
    output logic [NUM_PADS-1:0] pressed,
    output logic [NUM_PADS-1:0] press_pulse,
    output logic [NUM_PADS-1:0] toggle
);
    logic [NUM_PADS-1:0] low_raw;
    logic [NUM_PADS-1:0] touched;
    logic [NUM_PADS-1:0] rise;
    logic [NUM_PADS-1:0] prev_q, pulse_q, tog_q;

    always_comb begin
        low_raw = ~level;
        touched = (&low_raw) ? '0 : low_raw;
        rise    = touched & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            pulse_q <= '0;
            tog_q   <= '0;
        end else begin
            pulse_q <= valid ? rise : '0;
            if (valid) begin
                prev_q <= touched;
                tog_q  <= tog_q ^ rise;
            end
        end
    end

    assign pressed     = prev_q;
    assign press_pulse = pulse_q;
    assign toggle      = tog_q;

    // R5
    never_all_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pressed) < NUM_PADS);

    // R6
    pulse_in_pressed_chk: assert property (@(posedge clk) disable iff (rst)
        (press_pulse & ~pressed) == '0);

    // R7
    toggle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((toggle ^ $past(toggle)) == press_pulse));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pressed == '0 && press_pulse == '0 && toggle == '0));

endmodule

// File: rtl/touch_pad_sampler.sv
module touch_pad_sampler #(
    parameter int NUM_PADS      = 4,
    parameter int DRAIN_CYCLES  = 8,
    parameter int PERIOD_CYCLES = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pressed,
    output logic [NUM_PADS-1:0] press_pulse,
    output logic [NUM_PADS-1:0] toggle
);
    logic                strobe;
    logic                snap_valid;
    logic [NUM_PADS-1:0] snap_level;

    tps_sequencer #(
        .NUM_PADS      (NUM_PADS),
        .DRAIN_CYCLES  (DRAIN_CYCLES),
        .PERIOD_CYCLES (PERIOD_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .pad_oe (pad_oe),
        .strobe (strobe)
    );

    tps_sync #(
        .WIDTH  (NUM_PADS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (pad_in),
        .tag_in  (strobe),
        .q       (snap_level),
        .tag_out (snap_valid)
    );

    tps_decoder #(
        .NUM_PADS (NUM_PADS)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .valid       (snap_valid),
        .level       (snap_level),
        .pressed     (pressed),
        .press_pulse (press_pulse),
        .toggle      (toggle)
    );

    assign pad_out = '0;

endmodule

// File: tb/sim_touch_pad_sampler.sv
module sim_touch_pad_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int DRN  = 4;
    localparam int PER  = 16;
    localparam int SYN  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] pad_in, pad_oe, pad_out, pressed, press_pulse, toggle;

    logic [N-1:0] touch = '0;
    int thr_t = 2;
    int thr_f = 1;
    int rc [N];

    int n_checks = 0;
    int n_errors = 0;
    logic [N-1:0] exp_prev = '0;
    logic [N-1:0] exp_tog  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_pad_sampler #(
        .NUM_PADS(N), .DRAIN_CYCLES(DRN), .PERIOD_CYCLES(PER), .SYNC_STAGES(SYN)
    ) u0 (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pressed(pressed), .press_pulse(press_pulse), .toggle(toggle)
    );

    // resistor/capacitor model counted in clock cycles
    always @(posedge clk) begin
        for (int i = 0; i < N; i++)
            rc[i] <= pad_oe[i] ? 0 : ((rc[i] < 1000) ? rc[i] + 1 : rc[i]);
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] : (rc[i] >= (touch[i] ? thr_t : thr_f));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic scan(input logic [N-1:0] pat);
        logic [N-1:0] eff, exp_pulse;
        string tag;
        while (pad_oe != '1) @(negedge clk);
        touch = pat;
        while (pad_oe != '0) @(negedge clk);
        repeat (SYN + 2) @(negedge clk);
        eff = (pat == '1) ? '0 : pat;
        exp_pulse = eff & ~exp_prev;
        exp_tog = exp_tog ^ exp_pulse;
        if (pat == '1) tag = "R5";
        else if ($countones(pat) > 1) tag = "R4";
        else tag = "R3";
        check(pressed == eff, tag, pressed, eff);
        check(press_pulse == exp_pulse, "R6", press_pulse, exp_pulse);
        check(toggle == exp_tog, "R7", toggle, exp_tog);
        check(pad_out == '0, "R9", pad_out, 0);
        @(negedge clk);
        check(press_pulse == '0, "R6", press_pulse, 0);
        check(pressed == eff, "R3", pressed, eff);
        exp_prev = eff;
    endtask

    task automatic measure();
        int n, m;
        while (pad_oe != '0) @(negedge clk);
        while (pad_oe != '1) @(negedge clk);
        n = 0;
        while (pad_oe == '1) begin n++; @(negedge clk); end
        check(n == DRN, "R1", n, DRN);
        m = n;
        while (pad_oe != '1) begin
            check(pad_oe == '0, "R2", pad_oe, 0);
            m++;
            @(negedge clk);
        end
        check(m == PER, "R2", m, PER);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pressed == '0 && press_pulse == '0 && toggle == '0, "R8", {pressed, toggle}, 0);
        check(pad_oe == '1, "R1", pad_oe, 4'hF);
        rst = 1'b0;
        measure();
        measure();
        // exhaustive sweep over consecutive pattern pairs
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                scan(N'(a));
                scan(N'(b));
            end
        // late and early charging boundaries (R3)
        thr_f = 0;
        thr_t = 3;
        scan(4'h5);
        scan(4'hA);
        scan(4'h0);
        scan(4'h7);
        thr_f = 1;
        thr_t = 2;
        // reset in mid-run clears state (R8)
        scan(4'h3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(pressed == '0 && press_pulse == '0 && toggle == '0, "R8", {pressed, toggle}, 0);
        check(pad_oe == '1, "R1", pad_oe, 4'hF);
        rst = 1'b0;
        exp_prev = '0;
        exp_tog = '0;
        scan(4'h3);
        scan(4'hF);
        scan(4'h8);
        finish_run();
    end

endmodule